// File: doc/BRIEF.md
# Outstanding Transaction Routing Tracker

This block sits beside the arbiters of a multi-master, multi-slave AXI4-Lite fabric. It remembers, for every request that has been handed to a slave and not yet answered, which master issued it. That record is what lets a slave's response be steered back to the right master. It keeps one bookkeeping plane for the read path and a separate, identical plane for the write path. The two planes never interact, so read and write traffic can overlap freely.

Each plane holds an M x S grid of occupancy counters. Each counter is bounded at a depth of 8 and acts as a data-less FIFO for one master/slave pair. Each slave also has an order queue of master indices, kept in acceptance order. The arbiter for slave s offers a push carrying the winning master's index, and the block answers with a same-cycle ready. When the slave's response handshake completes, the fabric raises a pop for that slave. The head of the order queue names the master that owns the response, and that entry leaves the queue together with one unit of the matching pair's count. Requests between disjoint pairs, and requests to different slaves, are tracked in parallel.

Top module: `txn_route_tracker`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and right after it, every pair-full flag and every owner-valid output is 0, and every pop error output is 0 unless a pop is offered.
- R2: A push offered to slave s with master index m < M is accepted in the same cycle (push ready is 1, combinationally) whenever pair [m][s] holds fewer than 8 outstanding requests.
- R3: A pair holding 8 outstanding requests drives its full flag to 1 (flag bit m*S+s), and a push to that pair sees ready 0 and is not recorded.
- R4: The owner output of slave s is valid one cycle after the first accepted push into an empty slave, and it always names the master of the oldest unanswered request at that slave.
- R5: A pop to a slave with a valid owner removes that oldest entry, lowers the owner pair's count by one, and the next owner (or none) appears one cycle later.
- R6: A pop to a slave with no outstanding request drives that slave's pop error output to 1 in the same cycle and changes no state.
- R7: An accepted push and a pop that hit the same pair in the same cycle leave that pair's occupancy unchanged.
- R8: The read plane and the write plane are independent: traffic on one never changes the full flags, owners or readies of the other, and slaves are tracked independently of each other.
- R9: A push whose master index is M or larger is refused (ready 0) and leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_push_valid | input | NUM_SLV | Read plane: arbiter offers a request per slave |
| rd_push_mst | input | NUM_SLV*MW | Read plane: issuing master index per slave (MW bits each) |
| rd_push_ready | output | NUM_SLV | Read plane: request would be accepted this cycle |
| rd_pop_valid | input | NUM_SLV | Read plane: response handshake done at this slave |
| rd_pop_err | output | NUM_SLV | Read plane: response arrived with nothing outstanding |
| rd_owner_valid | output | NUM_SLV | Read plane: slave has an outstanding request |
| rd_owner_mst | output | NUM_SLV*MW | Read plane: master owning the oldest outstanding request |
| rd_pair_full | output | NUM_MST*NUM_SLV | Read plane: pair [m][s] full at bit m*NUM_SLV+s |
| wr_push_valid | input | NUM_SLV | Write plane: arbiter offers a request per slave |
| wr_push_mst | input | NUM_SLV*MW | Write plane: issuing master index per slave |
| wr_push_ready | output | NUM_SLV | Write plane: request would be accepted this cycle |
| wr_pop_valid | input | NUM_SLV | Write plane: response handshake done at this slave |
| wr_pop_err | output | NUM_SLV | Write plane: response arrived with nothing outstanding |
| wr_owner_valid | output | NUM_SLV | Write plane: slave has an outstanding request |
| wr_owner_mst | output | NUM_SLV*MW | Write plane: master owning the oldest outstanding request |
| wr_pair_full | output | NUM_MST*NUM_SLV | Write plane: pair [m][s] full at bit m*NUM_SLV+s |

## Verification
Push ready and pop error are combinational, so they are due in the same cycle as the stimulus that produces them. Owner and full flags come from registers, so they reflect a push or pop from the following cycle on. The bench changes inputs on the falling clock edge and samples every output one time unit later. It compares the outputs against a bench-side model that advances only at the rising edge. Same-cycle outputs are therefore judged against the model state before the edge, and registered outputs against the state after the previous edge.

// File: rtl/trk_pkg.sv
package trk_pkg;

    // Width of an index able to name n distinct items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter able to hold the value n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/trk_slave_lane.sv
module trk_slave_lane
    import trk_pkg::*;
#(
    parameter int NUM_MST = 3,
    parameter int DEPTH   = 8,
    localparam int MW     = idx_w(NUM_MST),
    localparam int CW     = cnt_w(DEPTH),
    localparam int QD     = NUM_MST * DEPTH,
    localparam int QAW    = idx_w(QD),
    localparam int QCW    = cnt_w(QD)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [MW-1:0]      push_mst,
    output logic               push_ready,
    input  logic               pop_valid,
    output logic               pop_err,
    output logic               owner_valid,
    output logic [MW-1:0]      owner_mst,
    output logic [NUM_MST-1:0] pair_full
);

    typedef struct packed {
        logic [QD-1:0][MW-1:0]      ord;
        logic [QAW-1:0]             head;
        logic [QAW-1:0]             tail;
        logic [QCW-1:0]             used;
        logic [NUM_MST-1:0][CW-1:0] occ;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic          idx_ok;
    logic          push_take;
    logic          pop_take;
    logic [MW-1:0] head_mst;

    assign head_mst    = st_q.ord[st_q.head];
    assign owner_valid = (st_q.used != '0);
    assign owner_mst   = head_mst;

    always_comb begin
        idx_ok     = (int'(push_mst) < NUM_MST);
        push_ready = 1'b0;
        if (idx_ok) begin
            push_ready = (st_q.occ[push_mst] != CW'(DEPTH));
        end
        push_take = push_valid && push_ready;
        pop_take  = pop_valid && owner_valid;
        pop_err   = pop_valid && !owner_valid;
    end

    always_comb begin
        st_d = st_q;
        if (pop_take) begin
            st_d.occ[head_mst] = st_d.occ[head_mst] - CW'(1);
            st_d.head = (st_q.head == QAW'(QD - 1)) ? '0 : st_q.head + QAW'(1);
        end
        if (push_take) begin
            st_d.occ[push_mst]  = st_d.occ[push_mst] + CW'(1);
            st_d.ord[st_q.tail] = push_mst;
            st_d.tail = (st_q.tail == QAW'(QD - 1)) ? '0 : st_q.tail + QAW'(1);
        end
        case ({push_take, pop_take})
            2'b10:   st_d.used = st_q.used + QCW'(1);
            2'b01:   st_d.used = st_q.used - QCW'(1);
            default: st_d.used = st_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar m = 0; m < NUM_MST; m++) begin : g_full
        assign pair_full[m] = (st_q.occ[m] == CW'(DEPTH));
    end

endmodule

// File: rtl/trk_channel.sv
module trk_channel
    import trk_pkg::*;
#(
    parameter int NUM_MST = 3,
    parameter int NUM_SLV = 2,
    parameter int DEPTH   = 8,
    localparam int MW     = idx_w(NUM_MST)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLV-1:0]         push_valid,
    input  logic [NUM_SLV*MW-1:0]      push_mst,
    output logic [NUM_SLV-1:0]         push_ready,
    input  logic [NUM_SLV-1:0]         pop_valid,
    output logic [NUM_SLV-1:0]         pop_err,
    output logic [NUM_SLV-1:0]         owner_valid,
    output logic [NUM_SLV*MW-1:0]      owner_mst,
    output logic [NUM_MST*NUM_SLV-1:0] pair_full
);

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_lane
        logic [NUM_MST-1:0] lane_full;

        trk_slave_lane #(
            .NUM_MST (NUM_MST),
            .DEPTH   (DEPTH)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_valid  (push_valid[s]),
            .push_mst    (push_mst[s*MW +: MW]),
            .push_ready  (push_ready[s]),
            .pop_valid   (pop_valid[s]),
            .pop_err     (pop_err[s]),
            .owner_valid (owner_valid[s]),
            .owner_mst   (owner_mst[s*MW +: MW]),
            .pair_full   (lane_full)
        );

        for (genvar m = 0; m < NUM_MST; m++) begin : g_map
            assign pair_full[m*NUM_SLV + s] = lane_full[m];
        end
    end

endmodule

// File: rtl/txn_route_tracker.sv
module txn_route_tracker
    import trk_pkg::*;
#(
    parameter int NUM_MST = 3,
    parameter int NUM_SLV = 2,
    parameter int DEPTH   = 8,
    localparam int MW     = idx_w(NUM_MST)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLV-1:0]         rd_push_valid,
    input  logic [NUM_SLV*MW-1:0]      rd_push_mst,
    output logic [NUM_SLV-1:0]         rd_push_ready,
    input  logic [NUM_SLV-1:0]         rd_pop_valid,
    output logic [NUM_SLV-1:0]         rd_pop_err,
    output logic [NUM_SLV-1:0]         rd_owner_valid,
    output logic [NUM_SLV*MW-1:0]      rd_owner_mst,
    output logic [NUM_MST*NUM_SLV-1:0] rd_pair_full,
    input  logic [NUM_SLV-1:0]         wr_push_valid,
    input  logic [NUM_SLV*MW-1:0]      wr_push_mst,
    output logic [NUM_SLV-1:0]         wr_push_ready,
    input  logic [NUM_SLV-1:0]         wr_pop_valid,
    output logic [NUM_SLV-1:0]         wr_pop_err,
    output logic [NUM_SLV-1:0]         wr_owner_valid,
    output logic [NUM_SLV*MW-1:0]      wr_owner_mst,
    output logic [NUM_MST*NUM_SLV-1:0] wr_pair_full
);

    trk_channel #(
        .NUM_MST (NUM_MST),
        .NUM_SLV (NUM_SLV),
        .DEPTH   (DEPTH)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_valid  (rd_push_valid),
        .push_mst    (rd_push_mst),
        .push_ready  (rd_push_ready),
        .pop_valid   (rd_pop_valid),
        .pop_err     (rd_pop_err),
        .owner_valid (rd_owner_valid),
        .owner_mst   (rd_owner_mst),
        .pair_full   (rd_pair_full)
    );

    trk_channel #(
        .NUM_MST (NUM_MST),
        .NUM_SLV (NUM_SLV),
        .DEPTH   (DEPTH)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_valid  (wr_push_valid),
        .push_mst    (wr_push_mst),
        .push_ready  (wr_push_ready),
        .pop_valid   (wr_pop_valid),
        .pop_err     (wr_pop_err),
        .owner_valid (wr_owner_valid),
        .owner_mst   (wr_owner_mst),
        .pair_full   (wr_pair_full)
    );

endmodule

// File: rtl/trk_checker.sv
module trk_checker
    import trk_pkg::*;
#(
    parameter int NUM_MST = 3,
    parameter int NUM_SLV = 2,
    parameter int DEPTH   = 8,
    localparam int MW     = idx_w(NUM_MST)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLV-1:0]         rd_push_valid,
    input logic [NUM_SLV*MW-1:0]      rd_push_mst,
    input logic [NUM_SLV-1:0]         rd_push_ready,
    input logic [NUM_SLV-1:0]         rd_pop_valid,
    input logic [NUM_SLV-1:0]         rd_pop_err,
    input logic [NUM_SLV-1:0]         rd_owner_valid,
    input logic [NUM_SLV*MW-1:0]      rd_owner_mst,
    input logic [NUM_MST*NUM_SLV-1:0] rd_pair_full,
    input logic [NUM_SLV-1:0]         wr_push_valid,
    input logic [NUM_SLV*MW-1:0]      wr_push_mst,
    input logic [NUM_SLV-1:0]         wr_push_ready,
    input logic [NUM_SLV-1:0]         wr_pop_valid,
    input logic [NUM_SLV-1:0]         wr_pop_err,
    input logic [NUM_SLV-1:0]         wr_owner_valid,
    input logic [NUM_SLV*MW-1:0]      wr_owner_mst,
    input logic [NUM_MST*NUM_SLV-1:0] wr_pair_full
);

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        AST_RD_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            rd_pop_err[s] |-> !rd_owner_valid[s]); // R6
        AST_WR_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            wr_pop_err[s] |-> !wr_owner_valid[s]); // R6
        AST_RD_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_owner_valid[s] && !rd_pop_valid[s]) |=>
            (rd_owner_valid[s] && $stable(rd_owner_mst[s*MW +: MW]))); // R5
        AST_WR_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_owner_valid[s] && !wr_pop_valid[s]) |=>
            (wr_owner_valid[s] && $stable(wr_owner_mst[s*MW +: MW]))); // R5
        AST_RD_FIRST_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_owner_valid[s] && rd_push_valid[s] && rd_push_ready[s]) |=>
            (rd_owner_valid[s] && rd_owner_mst[s*MW +: MW] == $past(rd_push_mst[s*MW +: MW]))); // R4
        AST_WR_FIRST_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_owner_valid[s] && wr_push_valid[s] && wr_push_ready[s]) |=>
            (wr_owner_valid[s] && wr_owner_mst[s*MW +: MW] == $past(wr_push_mst[s*MW +: MW]))); // R4

        for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
            AST_RD_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_pair_full[m*NUM_SLV + s] && int'(rd_push_mst[s*MW +: MW]) == m)
                |-> !rd_push_ready[s]); // R3
            AST_WR_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_pair_full[m*NUM_SLV + s] && int'(wr_push_mst[s*MW +: MW]) == m)
                |-> !wr_push_ready[s]); // R3
            AST_RD_FULL_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                rd_pair_full[m*NUM_SLV + s] |-> rd_owner_valid[s]); // R4
            AST_WR_FULL_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                wr_pair_full[m*NUM_SLV + s] |-> wr_owner_valid[s]); // R4
        end
    end

endmodule

bind txn_route_tracker trk_checker #(
    .NUM_MST (NUM_MST),
    .NUM_SLV (NUM_SLV),
    .DEPTH   (DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_push_valid  (rd_push_valid),
    .rd_push_mst    (rd_push_mst),
    .rd_push_ready  (rd_push_ready),
    .rd_pop_valid   (rd_pop_valid),
    .rd_pop_err     (rd_pop_err),
    .rd_owner_valid (rd_owner_valid),
    .rd_owner_mst   (rd_owner_mst),
    .rd_pair_full   (rd_pair_full),
    .wr_push_valid  (wr_push_valid),
    .wr_push_mst    (wr_push_mst),
    .wr_push_ready  (wr_push_ready),
    .wr_pop_valid   (wr_pop_valid),
    .wr_pop_err     (wr_pop_err),
    .wr_owner_valid (wr_owner_valid),
    .wr_owner_mst   (wr_owner_mst),
    .wr_pair_full   (wr_pair_full)
);

// File: tb/tb_txn_route_tracker.sv
module tb_txn_route_tracker;
    import trk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int NS = 2;
    localparam int DP = 8;
    localparam int MW = idx_w(NM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NS-1:0]    rd_push_valid, rd_push_ready, rd_pop_valid, rd_pop_err, rd_owner_valid;
    logic [NS*MW-1:0] rd_push_mst, rd_owner_mst;
    logic [NM*NS-1:0] rd_pair_full;
    logic [NS-1:0]    wr_push_valid, wr_push_ready, wr_pop_valid, wr_pop_err, wr_owner_valid;
    logic [NS*MW-1:0] wr_push_mst, wr_owner_mst;
    logic [NM*NS-1:0] wr_pair_full;

    // Stimulus per plane (0 = read, 1 = write) and slave.
    logic pv [2][NS];
    int   pm [2][NS];
    logic pp [2][NS];

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            rd_push_valid[s]         = pv[0][s];
            rd_push_mst[s*MW +: MW]  = MW'(pm[0][s]);
            rd_pop_valid[s]          = pp[0][s];
            wr_push_valid[s]         = pv[1][s];
            wr_push_mst[s*MW +: MW]  = MW'(pm[1][s]);
            wr_pop_valid[s]          = pp[1][s];
        end
    end

    txn_route_tracker #(.NUM_MST(NM), .NUM_SLV(NS), .DEPTH(DP)) dut (.*);

    // Bench model.
    int cnt [2][NM][NS];
    int oq  [2][NS][$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready(input int ch, input int s, input int m);
        return (m < NM) && (cnt[ch][m][s] < DP);
    endfunction

    function automatic int get_ready(input int ch, input int s);
        return ch == 0 ? int'(rd_push_ready[s]) : int'(wr_push_ready[s]);
    endfunction
    function automatic int get_err(input int ch, input int s);
        return ch == 0 ? int'(rd_pop_err[s]) : int'(wr_pop_err[s]);
    endfunction
    function automatic int get_ov(input int ch, input int s);
        return ch == 0 ? int'(rd_owner_valid[s]) : int'(wr_owner_valid[s]);
    endfunction
    function automatic int get_om(input int ch, input int s);
        return ch == 0 ? int'(rd_owner_mst[s*MW +: MW]) : int'(wr_owner_mst[s*MW +: MW]);
    endfunction
    function automatic int get_full(input int ch, input int m, input int s);
        return ch == 0 ? int'(rd_pair_full[m*NS+s]) : int'(wr_pair_full[m*NS+s]);
    endfunction

    // Compare every output with the model, then advance the model to the next edge.
    task automatic check_and_advance();
        #1;
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < NS; s++) begin
                automatic int er = int'(exp_ready(ch, s, pm[ch][s]));
                automatic int ee = int'(pp[ch][s] && oq[ch][s].size() == 0);
                automatic int ev = int'(oq[ch][s].size() != 0);
                if (pm[ch][s] >= NM)
                    chk(get_ready(ch, s) == er, "R9 ready", get_ready(ch, s), er);
                else if (er == 0)
                    chk(get_ready(ch, s) == er, "R3 ready", get_ready(ch, s), er);
                else
                    chk(get_ready(ch, s) == er, "R2 ready", get_ready(ch, s), er);
                chk(get_err(ch, s) == ee, "R6 pop_err", get_err(ch, s), ee);
                chk(get_ov(ch, s) == ev, "R4 R5 owner_valid", get_ov(ch, s), ev);
                if (ev != 0)
                    chk(get_om(ch, s) == oq[ch][s][0], "R4 R5 owner_mst", get_om(ch, s), oq[ch][s][0]);
                for (int m = 0; m < NM; m++) begin
                    automatic int ef = int'(cnt[ch][m][s] == DP);
                    chk(get_full(ch, m, s) == ef, "R3 R7 R8 pair_full", get_full(ch, m, s), ef);
                end
            end
        end
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < NS; s++) begin
                automatic bit take = pv[ch][s] && exp_ready(ch, s, pm[ch][s]);
                if (pp[ch][s] && oq[ch][s].size() != 0) begin
                    automatic int h = oq[ch][s].pop_front();
                    cnt[ch][h][s]--;
                end
                if (take) begin
                    cnt[ch][pm[ch][s]][s]++;
                    oq[ch][s].push_back(pm[ch][s]);
                end
            end
        end
    endtask

    task automatic idle_inputs();
        for (int ch = 0; ch < 2; ch++)
            for (int s = 0; s < NS; s++) begin
                pv[ch][s] = 1'b0; pm[ch][s] = 0; pp[ch][s] = 1'b0;
            end
    endtask

    task automatic cycle();
        check_and_advance();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int ch = 0; ch < 2; ch++)
            for (int m = 0; m < NM; m++)
                for (int s = 0; s < NS; s++) cnt[ch][m][s] = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        #1;
        chk(rd_owner_valid == '0 && wr_owner_valid == '0, "R1 owner_valid in reset",
            int'({rd_owner_valid, wr_owner_valid}), 0);
        chk(rd_pair_full == '0 && wr_pair_full == '0, "R1 pair_full in reset",
            int'({rd_pair_full, wr_pair_full}), 0);
        chk(rd_pop_err == '0 && wr_pop_err == '0, "R1 pop_err in reset",
            int'({rd_pop_err, wr_pop_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cycle();

        // R3: fill read pair [1][0], ninth push refused
        for (int i = 0; i < DP + 1; i++) begin
            pv[0][0] = 1'b1; pm[0][0] = 1;
            cycle();
        end
        idle_inputs();
        #1;
        chk(rd_pair_full[1*NS+0] == 1'b1, "R3 pair [1][0] full", int'(rd_pair_full[1*NS+0]), 1);
        // R8: write plane and other read slave untouched
        chk(wr_pair_full == '0 && wr_owner_valid == '0, "R8 write plane idle",
            int'({wr_pair_full, wr_owner_valid}), 0);
        chk(rd_owner_valid[1] == 1'b0, "R8 other slave idle", int'(rd_owner_valid[1]), 0);
        cycle();

        // R5: one pop drops pair to 7
        pp[0][0] = 1'b1;
        cycle();
        idle_inputs();
        #1;
        chk(rd_pair_full[1*NS+0] == 1'b0, "R5 pop lowers occupancy", int'(rd_pair_full[1*NS+0]), 0);
        // R7: push and pop same pair in one cycle keeps 7
        pv[0][0] = 1'b1; pm[0][0] = 1; pp[0][0] = 1'b1;
        cycle();
        idle_inputs();
        #1;
        chk(rd_pair_full[1*NS+0] == 1'b0, "R7 push+pop keeps 7", int'(rd_pair_full[1*NS+0]), 0);
        pv[0][0] = 1'b1; pm[0][0] = 1;
        cycle();
        idle_inputs();
        #1;
        chk(rd_pair_full[1*NS+0] == 1'b1, "R7 one more push reaches 8", int'(rd_pair_full[1*NS+0]), 1);
        cycle();

        // R9: out-of-range index on write slave 1
        pv[1][1] = 1'b1; pm[1][1] = NM;
        #1;
        chk(wr_push_ready[1] == 1'b0, "R9 refused index", int'(wr_push_ready[1]), 0);
        cycle();
        idle_inputs();
        #1;
        chk(wr_owner_valid[1] == 1'b0, "R9 no trace", int'(wr_owner_valid[1]), 0);
        // R6: pop with nothing outstanding
        pp[1][1] = 1'b1;
        #1;
        chk(wr_pop_err[1] == 1'b1, "R6 empty pop flagged", int'(wr_pop_err[1]), 1);
        cycle();
        idle_inputs();

        // Drain read slave 0
        for (int i = 0; i < DP; i++) begin
            pp[0][0] = 1'b1;
            cycle();
        end
        idle_inputs();

        // Random phases
        for (int i = 0; i < 4000; i++) begin
            automatic int pop_pct = ((i / 250) % 2 == 0) ? 15 : 70;
            for (int ch = 0; ch < 2; ch++)
                for (int s = 0; s < NS; s++) begin
                    pv[ch][s] = ($urandom_range(0, 99) < 60);
                    pm[ch][s] = ($urandom_range(0, 15) == 0) ? NM : int'($urandom_range(0, NM - 1));
                    pp[ch][s] = ($urandom_range(0, 99) < pop_pct);
                end
            cycle();
        end
        idle_inputs();
        cycle();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule